// File: doc/BRIEF.md
# CDR Lock Detect and Acquisition Controller

This block decides which detector steers a clock-and-data-recovery loop. It compares how often a divided recovered-clock enable fires against a reference clock enable, counting over a fixed window of reference cycles. If the two rates differ by more than a selectable threshold, the loop is handed to a phase-frequency comparator, which pulls the oscillator back toward the reference. Once the rates agree again, the loop is handed to a bang-bang data phase detector, which tracks the incoming data.

The recovery from an offset passes through a trial stage. For one full window the bang-bang detector is in the loop, but the block still counts as acquiring. If the next window also shows an in-range offset, the block declares CDR mode. If it does not, control goes back to the comparator. The lock output shows which detector holds the loop. It is steady high in CDR mode, and it alternates during acquisition as control moves between the detectors. Two manual settings pin the loop to either detector. The frequency check keeps running in every mode.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: With `lock_mode` = 2'b00 the comparator is forced into the loop. From the clock edge after the setting is seen, `use_bb`, `lock_out` and `in_cdr` are all 0, whatever the measured offset.
- R2: With `lock_mode` = 2'b01 the bang-bang detector is forced into the loop. From the clock edge after the setting is seen, `use_bb`, `lock_out` and `in_cdr` are all 1, whatever the measured offset.
- R3: A window ends on the WIN_LEN-th `ref_tick`. The offset is the absolute difference between WIN_LEN and the number of `vco_tick` cycles since the previous window end, counting the end cycle itself. The threshold is TH_NARROW when `lock_mode` = 2'b11 and TH_WIDE when `lock_mode` = 2'b10.
- R4: In an automatic mode (`lock_mode[1]` = 1), a window whose offset exceeds the threshold moves the block to comparator acquisition from any state. The outputs {use_bb, lock_out, in_cdr} then read 3'b000.
- R5: In an automatic mode, an in-range window during comparator acquisition moves the block to the bang-bang trial, where the outputs read 3'b110. An in-range window at the end of the trial moves the block to CDR mode.
- R6: In CDR mode the outputs read 3'b111 and `lock_out` stays high for as long as the mode lasts. An in-range window keeps the block in CDR mode, so the offset check continues during CDR mode.
- R7: In an automatic mode the outputs change only on the clock edge that ends a window.
- R8: Asynchronous reset (`rst_n` low) clears both counters and puts the block into comparator acquisition, with the outputs at 3'b000.
- R9: An offset equal to the threshold counts as in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| vco_tick | input | 1 | One-cycle enable per divided recovered-clock period |
| lock_mode | input | 2 | 00 manual comparator, 01 manual bang-bang, 10 auto wide threshold, 11 auto narrow threshold |
| use_bb | output | 1 | 1: bang-bang detector drives the loop; 0: comparator drives it |
| lock_out | output | 1 | Lock status, high whenever the bang-bang detector holds the loop |
| in_cdr | output | 1 | 1 in CDR mode, 0 during acquisition |

## Verification
The bench builds the block with WIN_LEN = 64, TH_NARROW = 2 and TH_WIDE = 5, so each window takes under a hundred cycles. With these values, every offset from −10 to +10 can be applied in both automatic modes, starting from each of the three states. This covers each transition and both threshold boundaries exactly. The manual settings are checked with offsets far outside either threshold. Each test window is also sampled at its midpoint, which shows that nothing changes between window ends.

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int WIN_LEN   = 16384,
  parameter int TH_NARROW = 8,
  parameter int TH_WIDE   = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       vco_tick,
  input  logic [1:0] lock_mode,
  output logic       use_bb,
  output logic       lock_out,
  output logic       in_cdr
);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int CNT_W = $clog2(WIN_LEN) + 2;
  localparam logic [CNT_W-1:0] NOM     = CNT_W'(WIN_LEN);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [1:0] ST_PFC = 2'd0, ST_TRY = 2'd1, ST_CDR = 2'd2;

  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] vco_cnt, vco_total, diff, thr;
  logic [1:0]       st;
  logic             win_done, in_range;

  assign win_done  = ref_tick && (win_cnt == WIN_W'(WIN_LEN - 1));
  assign vco_total = (vco_tick && vco_cnt != CNT_TOP) ? vco_cnt + 1'b1 : vco_cnt;
  assign diff      = (vco_total >= NOM) ? vco_total - NOM : NOM - vco_total;
  assign thr       = lock_mode[0] ? CNT_W'(TH_NARROW) : CNT_W'(TH_WIDE);
  assign in_range  = diff <= thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      vco_cnt <= '0;
    end else begin
      if (win_done) win_cnt <= '0;
      else if (ref_tick) win_cnt <= win_cnt + 1'b1;
      vco_cnt <= win_done ? '0 : vco_total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PFC;
    else if (lock_mode == 2'b00) st <= ST_PFC;
    else if (lock_mode == 2'b01) st <= ST_CDR;
    else if (win_done) begin
      if (!in_range) st <= ST_PFC;
      else if (st == ST_PFC) st <= ST_TRY;
      else st <= ST_CDR;
    end
  end

  assign use_bb   = (st != ST_PFC);
  assign in_cdr   = (st == ST_CDR);
  assign lock_out = in_cdr | (st == ST_TRY);
endmodule

module cdr_lock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lock_mode,
  input logic       win_done,
  input logic       use_bb,
  input logic       lock_out,
  input logic       in_cdr
);
  AST_MANUAL_PFC: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode == 2'b00) |=> (!use_bb && !lock_out && !in_cdr)); // R1
  AST_MANUAL_BB: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode == 2'b01) |=> (use_bb && lock_out && in_cdr)); // R2
  AST_CDR_LOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_cdr |-> (lock_out && use_bb)); // R6
  AST_LOCK_TRACKS_DET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cdr |-> (lock_out == use_bb)); // R5
  AST_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode[1] && !win_done) |=> ($stable(use_bb) && $stable(in_cdr))); // R7
  always @(posedge clk)
    if (!rst_n) AST_RESET_ACQ: assert (!use_bb && !lock_out && !in_cdr); // R8
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lock_mode(lock_mode), .win_done(win_done),
  .use_bb(use_bb), .lock_out(lock_out), .in_cdr(in_cdr)
);

// File: tb/sim_cdr_lock_ctrl.sv
module sim_cdr_lock_ctrl;
  localparam int WL = 64, TN = 2, TW = 5, BLK = 80;
  logic clk = 0, rst_n = 0, ref_tick = 0, vco_tick = 0;
  logic [1:0] lock_mode = 2'b11;
  logic use_bb, lock_out, in_cdr;
  int total = 0, bad = 0;
  bit finished = 0;

  cdr_lock_ctrl #(.WIN_LEN(WL), .TH_NARROW(TN), .TH_WIDE(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .lock_mode(lock_mode), .use_bb(use_bb), .lock_out(lock_out), .in_cdr(in_cdr));

  always #10 clk = ~clk;

  // state codes in bench: 0 comparator, 1 trial, 2 CDR; outputs 000 / 110 / 111
  function automatic logic [2:0] outs(int s);
    return (s == 0) ? 3'b000 : (s == 1) ? 3'b110 : 3'b111;
  endfunction

  task automatic check(string req, logic [2:0] exp);
    total++;
    if ({use_bb, lock_out, in_cdr} !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, {use_bb, lock_out, in_cdr}, exp);
    end
  endtask

  // one window: ref ticks on the last WL cycles, n vco ticks ending at window end
  task automatic run_win(int n, bit mid_chk, logic [2:0] mid_exp);
    for (int c = 0; c < BLK; c++) begin
      @(negedge clk);
      if (mid_chk && c == 40) check("R7 mid-window", mid_exp);
      ref_tick = (c >= BLK - WL);
      vco_tick = (c >= BLK - n);
    end
    @(negedge clk);
    ref_tick = 0;
    vco_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", 3'b000);
    rst_n = 1;
    @(negedge clk);
    check("R8 after release", 3'b000);

    // R1 / R2 manual modes ignore offset
    lock_mode = 2'b00; run_win(64, 0, 3'b000); check("R1 in range", 3'b000);
    run_win(74, 0, 3'b000); check("R1 far offset", 3'b000);
    lock_mode = 2'b01; run_win(40, 0, 3'b000); check("R2 far offset", 3'b111);
    run_win(64, 0, 3'b000); check("R2 in range", 3'b111);

    for (int m = 2; m < 4; m++) begin
      for (int s0 = 0; s0 < 3; s0++) begin
        for (int n = 54; n <= 74; n++) begin
          int th, d, s1;
          string req;
          th = (m == 3) ? TN : TW;
          d = (n > WL) ? n - WL : WL - n;
          if (s0 == 2) begin
            lock_mode = 2'b01; run_win(64, 0, 3'b000);
          end else begin
            lock_mode = 2'b00; run_win(64, 0, 3'b000);
            if (s0 == 1) begin
              lock_mode = 2'b11; run_win(64, 0, 3'b000);
              check("R5 trial entry", 3'b110);
            end
          end
          lock_mode = 2'(m);
          if (d > th) begin s1 = 0; req = "R4 out of range"; end
          else begin
            s1 = (s0 == 0) ? 1 : 2;
            req = (d == th) ? "R9 at threshold" : (s0 == 2) ? "R6 hold cdr" : "R5 in range";
          end
          run_win(n, 1, outs(s0));
          check($sformatf("%s R3 mode=%0d n=%0d from=%0d", req, m, n, s0), outs(s1));
        end
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule